// File: doc/BRIEF.md
# Fractional Baud and Frame Configuration

This block turns three small configuration registers (line control, integer divisor and fractional adjust) into the timing and format information that a serial transmitter and receiver need. From the reference clock it produces a one-cycle pulse at every sixteenth of a bit period, which a receiver uses for oversampling. It also produces a one-cycle pulse at every bit boundary. Alongside the pulses it presents the data width, the stop-bit count and the parity mode.

One bit period lasts sixteen times the integer divisor, plus sixteen, plus a 3-bit fractional count of extra reference clocks. The rate can therefore be set more finely than a pure integer divider allows. The period is split into sixteen slots. By default the extra clocks of the fraction are spread one each over the first slots. Each register is loaded through its own write-enable strobe. While the divisor register is zero the tick generator stays idle and a write leaves the presented frame format unchanged.

Top module: `baud_frame_cfg`

## Requirements
- R1: After reset every register is zero: no pulses, `tick_run` low, `data_bits` = 5, `two_stop` low, `parity_mode` = 2'b00 (none).
- R2: With divisor D > 0 and fraction F, `bit_tick` pulses every P = 16*D + F + 16 clocks. The first pulse after a divisor or fraction write presented in cycle w comes in cycle w + P.
- R3: Exactly sixteen `os_tick` pulses fall in each bit period, and `bit_tick` coincides with the sixteenth of them.
- R4: Slot i (0..15) of a bit period lasts D + 1 clocks, plus one more when i < F. F is the 3-bit `frac_wdata` value, 0..7.
- R5: While the divisor register holds zero, `tick_run` is low and neither pulse output is asserted.
- R6: A write that leaves the divisor register at zero does not change `data_bits`, `two_stop` or `parity_mode`.
- R7: The data width is line-control bits [1:0] plus 5 (5 to 8 bits). It is shown on `data_bits` in the cycle after the write.
- R8: Line-control bit 2 set selects two stop bits (`two_stop` high). Clear selects one stop bit.
- R9: Parity is off (2'b00) when line-control bit 3 is clear. When bit 3 is set the mode is even (2'b10) if bit 3 or bit 4 is set, so it is even whatever bit 4 holds. The odd code 2'b01 is never produced.
- R10: A divisor or fraction write restarts the bit period from its first slot. A line-control write leaves the tick phase untouched.
- R11: Line-control and fraction values written while the divisor is zero are kept. They take effect when a nonzero divisor is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_we | input | 1 | Write strobe for the line-control register |
| line_wdata | input | 5 | Line control: [1:0] width code, [2] two stop, [3] parity enable, [4] parity sense |
| div_we | input | 1 | Write strobe for the integer divisor |
| div_wdata | input | 16 | Integer divisor |
| frac_we | input | 1 | Write strobe for the fractional adjust |
| frac_wdata | input | 3 | Extra reference clocks per bit period |
| bit_tick | output | 1 | One-cycle pulse at each bit boundary |
| os_tick | output | 1 | One-cycle pulse at each sixteenth of a bit period |
| tick_run | output | 1 | High while the divisor is nonzero |
| data_bits | output | 4 | Data bits per frame, 5 to 8 |
| two_stop | output | 1 | High for two stop bits |
| parity_mode | output | 2 | 00 none, 01 odd, 10 even |

## Verification
The frame outputs are due in the cycle after the one in which the write strobe is high. The bench reads them a few nanoseconds after the following edge. Tick timing is checked against a free-running cycle stamp. For a write presented in cycle w, the driver queues the expected bit-boundary cycles w + P, w + 2P and so on, and the monitor checks each `bit_tick` against the head of that queue. The monitor also measures the gap between consecutive `os_tick` pulses against D + 1 + (slot < F). The first gap is counted from cycle w, so the first slot is due in cycle w + D + 1 + (F > 0).

// File: rtl/baud_frame_pkg.sv
package baud_frame_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_ODD  = 2'b01,
      PAR_EVEN = 2'b10
   } parity_e;

   typedef struct packed {
      logic [1:0] width_code;
      logic       two_stop;
      parity_e    parity;
   } frame_t;

   localparam int unsigned DATA_BITS_BASE = 5;

endpackage

// File: rtl/baud_frame_dec.sv
module baud_frame_dec
   import baud_frame_pkg::*;
#(
   parameter int LCR_W = 5
) (
   input  logic [LCR_W-1:0] line,
   output frame_t           frame
);

   localparam int WIDTH_LO  = 0;
   localparam int STOP_BIT  = 2;
   localparam int PEN_BIT   = 3;
   localparam int SENSE_BIT = 4;

   initial begin
      assert (LCR_W == SENSE_BIT + 1)
         else $error("baud_frame_dec: LCR_W must be %0d", SENSE_BIT + 1);
   end

   always_comb begin
      frame.width_code = line[WIDTH_LO +: 2];
      frame.two_stop   = line[STOP_BIT];
      if (!line[PEN_BIT]) begin
         frame.parity = PAR_NONE;
      end else if (line[PEN_BIT] | line[SENSE_BIT]) begin
         frame.parity = PAR_EVEN;
      end else begin
         frame.parity = PAR_ODD;
      end
   end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int DIV_W       = 16,
   parameter int FRAC_W      = 3,
   parameter int OS_LOG2     = 4,
   parameter bit FRAC_SPREAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic [DIV_W-1:0]  div,
   input  logic [FRAC_W-1:0] frac,
   output logic              run,
   output logic              os_tick,
   output logic              bit_tick
);

   localparam int OS_N  = 1 << OS_LOG2;
   localparam int WIDE  = (DIV_W > FRAC_W) ? DIV_W : FRAC_W;
   localparam int CNT_W = WIDE + 2;
   localparam logic [OS_LOG2-1:0] IDX_LAST = OS_LOG2'(OS_N - 1);

   initial begin
      assert (DIV_W >= 2) else $error("baud_tick_gen: DIV_W too small");
      assert (FRAC_W >= 1) else $error("baud_tick_gen: FRAC_W too small");
      assert (OS_LOG2 >= 1 && OS_LOG2 <= 8)
         else $error("baud_tick_gen: OS_LOG2 out of range");
      assert (!FRAC_SPREAD || ((1 << FRAC_W) - 1) <= OS_N)
         else $error("baud_tick_gen: fraction exceeds slot count");
   end

   logic [CNT_W-1:0]   slot_cnt;
   logic [CNT_W-1:0]   slot_len;
   logic [CNT_W-1:0]   extra;
   logic [CNT_W-1:0]   frac_ext;
   logic [CNT_W-1:0]   idx_ext;
   logic [OS_LOG2-1:0] slot_idx;
   logic               slot_end;
   logic               last_slot;

   assign frac_ext  = CNT_W'(frac);
   assign idx_ext   = CNT_W'(slot_idx);
   assign last_slot = (slot_idx == IDX_LAST);
   assign run       = |div;

   generate
      if (FRAC_SPREAD) begin : g_spread
         assign extra = (idx_ext < frac_ext) ? CNT_W'(1) : '0;
      end else begin : g_lump
         assign extra = last_slot ? frac_ext : '0;
      end
   endgenerate

   assign slot_len = CNT_W'(div) + CNT_W'(1) + extra;
   assign slot_end = run && (slot_cnt == slot_len - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_cnt <= '0;
         slot_idx <= '0;
      end else if (reload || !run) begin
         slot_cnt <= '0;
         slot_idx <= '0;
      end else if (slot_end) begin
         slot_cnt <= '0;
         slot_idx <= slot_idx + OS_LOG2'(1);
      end else begin
         slot_cnt <= slot_cnt + CNT_W'(1);
      end
   end

   assign os_tick  = slot_end;
   assign bit_tick = slot_end && last_slot;

   // R4: the slot counter never passes the end of its slot
   p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (slot_cnt < slot_len));

   // R10: a reload restarts at the first slot
   p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (slot_cnt == '0 && slot_idx == '0));

   // R3: the bit boundary returns the slot index to zero
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> (slot_idx == '0));

endmodule

// File: rtl/baud_frame_cfg.sv
module baud_frame_cfg
   import baud_frame_pkg::*;
#(
   parameter int LCR_W       = 5,
   parameter int DIV_W       = 16,
   parameter int FRAC_W      = 3,
   parameter int OS_LOG2     = 4,
   parameter bit FRAC_SPREAD = 1'b1,
   parameter int DBITS_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_we,
   input  logic [LCR_W-1:0]  line_wdata,
   input  logic              div_we,
   input  logic [DIV_W-1:0]  div_wdata,
   input  logic              frac_we,
   input  logic [FRAC_W-1:0] frac_wdata,
   output logic              bit_tick,
   output logic              os_tick,
   output logic              tick_run,
   output logic [DBITS_W-1:0] data_bits,
   output logic              two_stop,
   output logic [1:0]        parity_mode
);

   initial begin
      assert (DBITS_W >= 4) else $error("baud_frame_cfg: DBITS_W too small");
   end

   logic [LCR_W-1:0]  lcr_q,  lcr_n;
   logic [DIV_W-1:0]  div_q,  div_n;
   logic [FRAC_W-1:0] frac_q, frac_n;
   logic              any_we;
   logic              eval;
   logic              reload;
   frame_t            frame_n, frame_q;
   logic              os_w, bit_w, run_w;

   assign lcr_n  = line_we ? line_wdata : lcr_q;
   assign div_n  = div_we  ? div_wdata  : div_q;
   assign frac_n = frac_we ? frac_wdata : frac_q;
   assign any_we = line_we | div_we | frac_we;
   assign eval   = any_we && (div_n != '0);
   assign reload = div_we | frac_we;

   baud_frame_dec #(.LCR_W(LCR_W)) u_dec (
      .line  (lcr_n),
      .frame (frame_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q   <= '0;
         div_q   <= '0;
         frac_q  <= '0;
         frame_q <= '0;
      end else begin
         lcr_q  <= lcr_n;
         div_q  <= div_n;
         frac_q <= frac_n;
         if (eval) begin
            frame_q <= frame_n;
         end
      end
   end

   baud_tick_gen #(
      .DIV_W       (DIV_W),
      .FRAC_W      (FRAC_W),
      .OS_LOG2     (OS_LOG2),
      .FRAC_SPREAD (FRAC_SPREAD)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (reload),
      .div      (div_q),
      .frac     (frac_q),
      .run      (run_w),
      .os_tick  (os_w),
      .bit_tick (bit_w)
   );

   assign bit_tick    = bit_w;
   assign os_tick     = os_w;
   assign tick_run    = run_w;
   assign data_bits   = DBITS_W'(frame_q.width_code) + DBITS_W'(DATA_BITS_BASE);
   assign two_stop    = frame_q.two_stop;
   assign parity_mode = frame_q.parity;

   // R5: no sub-bit pulse while the divisor register is zero
   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == '0) |-> !os_w);

   // R6: a write that leaves the divisor at zero keeps the frame
   p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (any_we && div_n == '0) |=> $stable(frame_q));

   // R9: the odd code never reaches the frame register
   p_no_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_q.parity != PAR_ODD);

endmodule

// File: tb/baud_frame_cfg_tb_top.sv
`timescale 1ns/1ps
module baud_frame_cfg_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_we = 1'b0;
   logic [4:0]  line_wdata = '0;
   logic        div_we = 1'b0;
   logic [15:0] div_wdata = '0;
   logic        frac_we = 1'b0;
   logic [2:0]  frac_wdata = '0;
   logic        bit_tick, os_tick, tick_run, two_stop;
   logic [3:0]  data_bits;
   logic [1:0]  parity_mode;

   always #10 clk = ~clk;

   baud_frame_cfg dut_i (
      .clk(clk), .rst_n(rst_n),
      .line_we(line_we), .line_wdata(line_wdata),
      .div_we(div_we), .div_wdata(div_wdata),
      .frac_we(frac_we), .frac_wdata(frac_wdata),
      .bit_tick(bit_tick), .os_tick(os_tick), .tick_run(tick_run),
      .data_bits(data_bits), .two_stop(two_stop), .parity_mode(parity_mode)
   );

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int unsigned exp_q[$];
   int nchk = 0, nfail = 0, mchk = 0, mfail = 0;
   int unsigned cur_div = 0, cur_frac = 0;
   int unsigned rl_req = 0, rl_cyc = 0;
   int unsigned drv_div = 0, drv_frac = 0;
   int unsigned next_tick = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic mchk_t(input bit ok, input string req, input int unsigned act, input int unsigned exp);
      mchk++;
      if (!ok) begin
         mfail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: pops expected bit boundaries, measures slot gaps
   int unsigned rl_seen = 0, last_os = 0, os_idx = 0, gap = 0, egap = 0, head = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rl_seen != rl_req) begin
            rl_seen = rl_req;
            last_os = rl_cyc;
            os_idx  = 0;
         end
         if (os_tick) begin
            mchk_t(cur_div != 0, "R5 os_tick while idle", 1, 0);
            gap  = cyc - last_os;
            egap = cur_div + 1 + ((os_idx < cur_frac) ? 1 : 0);
            mchk_t(gap == egap, "R4 slot length", gap, egap);
            mchk_t(bit_tick == (os_idx == 15), "R3 bit_tick on sixteenth slot", bit_tick, os_idx == 15);
            last_os = cyc;
            os_idx  = (os_idx + 1) % 16;
         end
         if (bit_tick) begin
            mchk_t(os_tick, "R3 bit_tick without os_tick", os_tick, 1);
            if (exp_q.size() == 0) begin
               mchk_t(1'b0, "R2 unexpected bit_tick", cyc, 0);
            end else begin
               head = exp_q.pop_front();
               mchk_t(cyc == head, "R2 bit_tick cycle", cyc, head);
            end
         end
      end
   end

   function automatic int unsigned period(input int unsigned d, input int unsigned f);
      return 16 * d + f + 16;
   endfunction

   // kind: 0 line control, 1 divisor, 2 fraction
   task automatic wr(input int kind, input int unsigned val);
      int unsigned w;
      @(posedge clk); #2;
      case (kind)
         0: begin line_we = 1'b1; line_wdata = 5'(val); end
         1: begin div_we = 1'b1; div_wdata = 16'(val); end
         default: begin frac_we = 1'b1; frac_wdata = 3'(val); end
      endcase
      w = cyc;
      @(posedge clk); #2;
      line_we = 1'b0; div_we = 1'b0; frac_we = 1'b0;
      if (kind == 1) drv_div = val;
      if (kind == 2) drv_frac = val & 7;
      if (kind != 0) begin
         cur_div  = drv_div;
         cur_frac = drv_frac;
         if (drv_div != 0) begin
            rl_cyc = w;
            rl_req++;
            next_tick = w + period(drv_div, drv_frac);
         end
      end
   endtask

   task automatic expect_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(next_tick);
         next_tick += period(drv_div, drv_frac);
      end
   endtask

   task automatic drain(input string req);
      int k = 0;
      while (exp_q.size() != 0 && k < 5000) begin
         @(negedge clk);
         k++;
      end
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      @(negedge clk);
   endtask

   task automatic chk_frame(input string req, input int unsigned db, input bit ts, input int unsigned pm);
      chk(data_bits == 4'(db), {req, " data_bits"}, data_bits, db);
      chk(two_stop == ts, {req, " two_stop"}, two_stop, ts);
      chk(parity_mode == 2'(pm), {req, " parity_mode"}, parity_mode, pm);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", (nchk + mchk) - (nfail + mfail), nchk + mchk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         chk(1'b0, "watchdog expired", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #2;
      chk_frame("R1 during reset", 5, 0, 0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk_frame("R1 after reset", 5, 0, 0);
      chk(tick_run == 0, "R1 tick_run", tick_run, 0);
      repeat (50) @(posedge clk);
      chk(tick_run == 0, "R5 idle with zero divisor", tick_run, 0);

      // held while divisor is zero
      wr(0, 5'h03);
      chk_frame("R6 line write with zero divisor", 5, 0, 0);
      wr(2, 3);
      chk(tick_run == 0, "R5 fraction write keeps idle", tick_run, 0);

      // nonzero divisor: held settings take effect, P = 51
      wr(1, 2);
      chk(tick_run == 1, "R2 tick_run with nonzero divisor", tick_run, 1);
      chk_frame("R11 held line control applied", 8, 0, 0);
      expect_ticks(3);
      drain("R2 three bit periods");

      // line control while running: phase untouched
      repeat (10) @(posedge clk);
      wr(0, 5'h0C);
      chk_frame("R8 R9 two stop even", 5, 1, 2);
      expect_ticks(2);
      drain("R10 line write keeps phase");
      wr(0, 5'h1D);
      chk_frame("R7 R9 six bits even with sense set", 6, 1, 2);
      expect_ticks(1);
      drain("R10 line write keeps phase again");
      wr(0, 5'h12);
      chk_frame("R7 R9 sense alone gives no parity", 7, 0, 0);
      expect_ticks(1);
      drain("R10 third line write");

      // mid-period divisor change restarts, P = 35
      repeat (20) @(posedge clk);
      wr(1, 1);
      expect_ticks(3);
      drain("R10 divisor reload mid period");

      // zero fraction, P = 32
      wr(2, 0);
      expect_ticks(2);
      drain("R2 zero fraction");

      // largest fraction then larger divisor, P = 103
      wr(2, 7);
      expect_ticks(1);
      drain("R4 fraction seven");
      wr(1, 5);
      expect_ticks(2);
      drain("R2 divisor five fraction seven");

      // back to zero divisor
      wr(1, 0);
      chk(tick_run == 0, "R5 divisor cleared", tick_run, 0);
      chk_frame("R6 zero divisor write keeps frame", 7, 0, 0);
      wr(0, 5'h07);
      chk_frame("R6 line write ignored while idle", 7, 0, 0);
      repeat (200) @(posedge clk);
      #2;
      chk(tick_run == 0, "R5 still idle", tick_run, 0);

      // nonzero divisor again: P = 71
      wr(1, 3);
      chk_frame("R11 held line applied on divisor write", 8, 1, 0);
      expect_ticks(2);
      drain("R2 divisor three fraction seven");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule